// File: doc/BRIEF.md
# Restricted-Access Priority Crossbar

This block connects a set of requesting masters to a set of target slaves. Each master presents one request at a time: a target slave index, a read/write direction and a burst length in beats. It holds the request until the crossbar pulses its completion strobe. Each slave carries a fixed mask of the masters allowed to reach it. A request outside that mask finishes at once with an error and never takes the slave. At most one master owns a slave at any time. Among the pending requesters, the one with the highest fixed priority wins. On a priority tie the lowest master index wins.

A granted transfer first waits out a latency. That latency is the master's issue delay for the direction, plus the slave's accept delay for the direction, plus a switch-over penalty when the new owner differs from the slave's previous owner. The burst then moves one beat per cycle while the slave's ready input is high. Ownership changes only between transfers, never inside a burst. A lockable slave can be pinned to one master through a lock input, and while the lock is set every other master waits. All priorities, masks and delays are elaboration-time parameters.

Top module: `prio_xbar`

## Requirements
- R1: After reset no slave is busy and no master sees a completion strobe.
- R2: A transfer granted at a clock edge with no contention completes with its last beat L+B cycles after the request is first seen, where B = len+1 beats and L = issue(master,dir) + accept(slave,dir). The default issue delays are read 2/2/3 and write 4/4/5 for masters 0/1/2. The default accept delays are read 1/4 and write 1/4 for slaves 0/1. Direction encoding: write=1, read=0.
- R3: The switch-over penalty (default 2 cycles) is added to L only when the slave has had a previous owner and that owner differs from the new one. The first transfer after reset and a repeat by the same master pay no penalty.
- R4: A request to a slave whose permission mask excludes the master completes in the same cycle with m_err=1, and that slave stays idle. By default slave 0 admits masters 0, 1 and 2, and slave 1 admits masters 1 and 2 only.
- R5: Among masters pending on an idle slave, the one with the highest priority value is granted. The default priorities are 1/1/3 for masters 0/1/2.
- R6: Between pending masters of equal priority, the lowest master index is granted.
- R7: Ownership never changes during a transfer. After a completion, the slave is idle for one cycle before the next grant.
- R8: While a slave's ready input is low in the data phase, no beat moves. Each such cycle delays completion by one cycle.
- R9: While the lock is set on a lockable slave (default: slave 0 only), only the lock master is granted that slave. On a slave that is not lockable, the lock input has no effect.
- R10: A beat strobe appears only while its slave is busy, and no master owns more than one slave at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | NM | Request pending, one bit per master |
| m_target | input | NM*SW | Target slave index per master |
| m_write | input | NM | Direction per master (1 = write) |
| m_len | input | NM*LW | Burst length minus one per master |
| m_done | output | NM | Completion strobe per master |
| m_err | output | NM | Permission error, valid with m_done |
| lock_en | input | NS | Lock request per slave |
| lock_id | input | NS*MW | Master index a locked slave is pinned to |
| s_ready | input | NS | Slave can move a beat this cycle |
| s_busy | output | NS | Slave owned by a transfer |
| s_owner | output | NS*MW | Current owner index per slave |
| s_write | output | NS | Direction of the current transfer |
| s_beat | output | NS | One data beat moves this cycle |

## Verification
A denied request has its error strobe in the cycle the request appears. A granted uncontended one completes L+B cycles after its request, plus 2 when the owner changes and plus one per stalled cycle. A waiting master is granted one idle cycle after the previous completion on that slave, and its latency then starts counting. The bench numbers every falling edge from the start of a scenario and drives inputs on those edges. It samples one time step later and records the edge index at which each completion strobe shows. It compares that index with the sum it builds from its own delay tables, owner history and stall count.

// File: rtl/prio_xbar_pkg.sv
package prio_xbar_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_DATA} phase_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/prio_xbar_pick.sv
module prio_xbar_pick #(
  parameter int NM = 3,
  parameter int PW = 4,
  parameter int MW = 2,
  parameter logic [NM*PW-1:0] PRIO = '0
) (
  input  logic [NM-1:0] cand,
  output logic          any,
  output logic [MW-1:0] idx
);
  logic [PW-1:0] best;

  // strict greater-than keeps the lowest index on a tie
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int m = 0; m < NM; m++) begin
      if (cand[m] && (!any || PRIO[m*PW +: PW] > best)) begin
        any  = 1'b1;
        idx  = MW'(m);
        best = PRIO[m*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/prio_xbar_port.sv
module prio_xbar_port
  import prio_xbar_pkg::*;
#(
  parameter int NM = 3,
  parameter int LW = 2,
  parameter int DLY_W = 4,
  parameter int PW = 4,
  parameter int MW = 2,
  parameter logic [NM*PW-1:0] PRIO = '0,
  parameter logic [NM*DLY_W-1:0] RD_ISSUE = '0,
  parameter logic [NM*DLY_W-1:0] WR_ISSUE = '0,
  parameter logic [DLY_W-1:0] RD_ACC = '0,
  parameter logic [DLY_W-1:0] WR_ACC = '0,
  parameter bit LOCK_OK = 1'b0,
  parameter int SWITCH_PEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    want,
  input  logic [NM-1:0]    m_write,
  input  logic [NM*LW-1:0] m_len,
  input  logic             lock_en,
  input  logic [MW-1:0]    lock_id,
  input  logic             ready,
  output logic             busy,
  output logic [MW-1:0]    owner,
  output logic             wr,
  output logic             beat,
  output logic             last,
  output logic             grant
);
  localparam int CW = DLY_W + 2;

  phase_e          phase;
  logic [MW-1:0]   owner_q, prev_owner, pick;
  logic            have_prev, wr_q, any;
  logic [LW-1:0]   len_q, beat_cnt;
  logic [CW-1:0]   wait_cnt, lat;
  logic [NM-1:0]   lock_mask, elig;
  logic            switched;

  function automatic logic [CW-1:0] xfer_lat(input logic [MW-1:0] m,
                                             input logic w, input logic sw);
    logic [CW-1:0] iss, acc;
    iss = w ? CW'(WR_ISSUE[m*DLY_W +: DLY_W]) : CW'(RD_ISSUE[m*DLY_W +: DLY_W]);
    acc = w ? CW'(WR_ACC) : CW'(RD_ACC);
    return iss + acc + (sw ? CW'(SWITCH_PEN) : '0);
  endfunction

  always_comb begin
    lock_mask = '1;
    if (LOCK_OK && lock_en) lock_mask = NM'(1) << lock_id;
  end
  assign elig = want & lock_mask;

  prio_xbar_pick #(.NM(NM), .PW(PW), .MW(MW), .PRIO(PRIO)) u_pick (
    .cand(elig), .any(any), .idx(pick)
  );

  assign grant    = (phase == PH_IDLE) && any;
  assign switched = have_prev && (prev_owner != pick);
  assign lat      = xfer_lat(pick, m_write[pick], switched);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      owner_q    <= '0;
      prev_owner <= '0;
      have_prev  <= 1'b0;
      wr_q       <= 1'b0;
      len_q      <= '0;
      beat_cnt   <= '0;
      wait_cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (grant) begin
          owner_q    <= pick;
          prev_owner <= pick;
          have_prev  <= 1'b1;
          wr_q       <= m_write[pick];
          len_q      <= m_len[pick*LW +: LW];
          beat_cnt   <= '0;
          wait_cnt   <= lat;
          phase      <= (lat == '0) ? PH_DATA : PH_WAIT;
        end
        PH_WAIT: begin
          wait_cnt <= wait_cnt - 1'b1;
          if (wait_cnt == CW'(1)) phase <= PH_DATA;
        end
        PH_DATA: if (ready) begin
          if (beat_cnt == len_q) phase <= PH_IDLE;
          else beat_cnt <= beat_cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy  = (phase != PH_IDLE);
  assign owner = owner_q;
  assign wr    = wr_q;
  assign beat  = (phase == PH_DATA) && ready;
  assign last  = beat && (beat_cnt == len_q);
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
  import prio_xbar_pkg::*;
#(
  parameter int NM = 3,
  parameter int NS = 2,
  parameter int LW = 2,
  parameter int DLY_W = 4,
  parameter int PW = 4,
  parameter logic [NM*PW-1:0]    PRIO      = {4'd3, 4'd1, 4'd1},
  parameter logic [NM*DLY_W-1:0] RD_ISSUE  = {4'd3, 4'd2, 4'd2},
  parameter logic [NM*DLY_W-1:0] WR_ISSUE  = {4'd5, 4'd4, 4'd4},
  parameter logic [NS*DLY_W-1:0] RD_ACCEPT = {4'd4, 4'd1},
  parameter logic [NS*DLY_W-1:0] WR_ACCEPT = {4'd4, 4'd1},
  parameter logic [NS*NM-1:0]    PERMIT    = {3'b110, 3'b111},
  parameter logic [NS-1:0]       LOCKABLE  = 2'b01,
  parameter int SWITCH_PEN = 2,
  localparam int MW = idx_w(NM),
  localparam int SW = idx_w(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_valid,
  input  logic [NM*SW-1:0] m_target,
  input  logic [NM-1:0]    m_write,
  input  logic [NM*LW-1:0] m_len,
  output logic [NM-1:0]    m_done,
  output logic [NM-1:0]    m_err,
  input  logic [NS-1:0]    lock_en,
  input  logic [NS*MW-1:0] lock_id,
  input  logic [NS-1:0]    s_ready,
  output logic [NS-1:0]    s_busy,
  output logic [NS*MW-1:0] s_owner,
  output logic [NS-1:0]    s_write,
  output logic [NS-1:0]    s_beat
);
  logic [NS-1:0] last_v, grant_v;
  logic [NM-1:0] denied;

  // permission gate per master
  always_comb begin
    for (int m = 0; m < NM; m++) begin
      int t;
      t = int'(m_target[m*SW +: SW]);
      denied[m] = m_valid[m] && !((t < NS) && PERMIT[t*NM + m]);
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_port
    logic [NM-1:0] want;
    for (genvar m = 0; m < NM; m++) begin : g_want
      assign want[m] = m_valid[m] && (m_target[m*SW +: SW] == SW'(s)) && PERMIT[s*NM + m];
    end
    prio_xbar_port #(
      .NM(NM), .LW(LW), .DLY_W(DLY_W), .PW(PW), .MW(MW), .PRIO(PRIO),
      .RD_ISSUE(RD_ISSUE), .WR_ISSUE(WR_ISSUE),
      .RD_ACC(RD_ACCEPT[s*DLY_W +: DLY_W]), .WR_ACC(WR_ACCEPT[s*DLY_W +: DLY_W]),
      .LOCK_OK(LOCKABLE[s]), .SWITCH_PEN(SWITCH_PEN)
    ) u_port (
      .clk(clk), .rst_n(rst_n), .want(want), .m_write(m_write), .m_len(m_len),
      .lock_en(lock_en[s]), .lock_id(lock_id[s*MW +: MW]), .ready(s_ready[s]),
      .busy(s_busy[s]), .owner(s_owner[s*MW +: MW]), .wr(s_write[s]),
      .beat(s_beat[s]), .last(last_v[s]), .grant(grant_v[s])
    );
  end

  // completion routing back to the owning master
  always_comb begin
    for (int m = 0; m < NM; m++) begin
      m_err[m]  = denied[m];
      m_done[m] = denied[m];
      for (int s = 0; s < NS; s++)
        if (last_v[s] && s_owner[s*MW +: MW] == MW'(m)) m_done[m] = 1'b1;
    end
  end
endmodule

// File: rtl/prio_xbar_chk.sv
module prio_xbar_chk #(
  parameter int NM = 3,
  parameter int NS = 2,
  parameter int MW = 2,
  parameter logic [NS*NM-1:0] PERMIT = '0,
  parameter logic [NS-1:0] LOCKABLE = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM-1:0]    m_err,
  input logic [NS-1:0]    s_busy,
  input logic [NS*MW-1:0] s_owner,
  input logic [NS-1:0]    s_beat,
  input logic [NS-1:0]    last_v,
  input logic [NS-1:0]    grant_v,
  input logic [NS-1:0]    lock_en,
  input logic [NS*MW-1:0] lock_id
);
  logic [NS-1:0] holds [NM];
  logic [NS-1:0] owner_ok;

  always_comb begin
    for (int m = 0; m < NM; m++)
      for (int s = 0; s < NS; s++)
        holds[m][s] = s_busy[s] && (s_owner[s*MW +: MW] == MW'(m));
    for (int s = 0; s < NS; s++)
      owner_ok[s] = PERMIT[s*NM + int'(s_owner[s*MW +: MW])];
  end

  for (genvar s = 0; s < NS; s++) begin : g_s
    AST_BEAT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      s_beat[s] |-> s_busy[s]); // R10
    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(s_busy[s]) && !$past(last_v[s])) |-> (s_busy[s] && $stable(s_owner[s*MW +: MW]))); // R7
    AST_GRANT_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
      grant_v[s] |=> owner_ok[s]); // R4
    if (LOCKABLE[s]) begin : g_lk
      AST_LOCK_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_v[s] && lock_en[s]) |=> (s_owner[s*MW +: MW] == $past(lock_id[s*MW +: MW]))); // R9
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_m
    AST_ONE_SLAVE_PER_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(holds[m])); // R10
    AST_DENIED_HOLDS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[m] |-> (holds[m] == '0)); // R4
  end
endmodule

bind prio_xbar prio_xbar_chk #(
  .NM(NM), .NS(NS), .MW(MW), .PERMIT(PERMIT), .LOCKABLE(LOCKABLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_err(m_err), .s_busy(s_busy), .s_owner(s_owner),
  .s_beat(s_beat), .last_v(last_v), .grant_v(grant_v), .lock_en(lock_en),
  .lock_id(lock_id)
);

// File: tb/prio_xbar_test.sv
module prio_xbar_test;
  localparam int NM = 3, NS = 2, LW = 2, MW = 2, SW = 1, PEN = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NM-1:0] m_valid = '0, m_write = '0, m_done, m_err;
  logic [NM*SW-1:0] m_target = '0;
  logic [NM*LW-1:0] m_len = '0;
  logic [NS-1:0] lock_en = '0, s_ready = '1, s_busy, s_write, s_beat;
  logic [NS*MW-1:0] lock_id = '0, s_owner;

  always #2 clk = ~clk;

  prio_xbar uut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_target(m_target),
    .m_write(m_write), .m_len(m_len), .m_done(m_done), .m_err(m_err),
    .lock_en(lock_en), .lock_id(lock_id), .s_ready(s_ready), .s_busy(s_busy),
    .s_owner(s_owner), .s_write(s_write), .s_beat(s_beat)
  );

  int n_run = 0, n_fail = 0;
  int last_own [NS];
  int act [NM], tgt [NM], dir [NM], ln [NM], st [NM], fin [NM], er [NM];
  int rdy_on [NS];
  int lock_off;

  function automatic int iss(int m, int w);
    if (w != 0) return (m == 2) ? 5 : 4;
    return (m == 2) ? 3 : 2;
  endfunction
  function automatic int acc(int s, int w);
    return (s == 0) ? 1 : 4 + 0 * w;
  endfunction
  function automatic int allowed(int m, int s);
    return (s == 1 && m == 0) ? 0 : 1;
  endfunction
  // latency including the owner-change penalty, updating the owner history
  function automatic int due(int m, int s, int w);
    int l;
    l = iss(m, w) + acc(s, w);
    if (last_own[s] >= 0 && last_own[s] != m) l += PEN;
    last_own[s] = m;
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic clear_plan();
    for (int m = 0; m < NM; m++) begin act[m] = 0; fin[m] = -1; er[m] = 0; st[m] = 0; end
    for (int s = 0; s < NS; s++) rdy_on[s] = 0;
    lock_off = -1;
  endtask

  task automatic run_plan(input int limit);
    int t, open;
    t = 0;
    open = 1;
    while (open != 0 && t < limit) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) s_ready[s] = (t >= rdy_on[s]);
      if (t == lock_off) lock_en = '0;
      for (int m = 0; m < NM; m++)
        if (act[m] != 0 && t == st[m]) begin
          m_target[m*SW +: SW] = SW'(tgt[m]);
          m_write[m] = dir[m][0];
          m_len[m*LW +: LW] = LW'(ln[m]);
          m_valid[m] = 1'b1;
        end
      #1;
      for (int m = 0; m < NM; m++)
        if (m_valid[m] && m_done[m]) begin
          fin[m] = t;
          er[m] = int'(m_err[m]);
          m_valid[m] = 1'b0;
        end
      open = 0;
      for (int m = 0; m < NM; m++) if (act[m] != 0 && fin[m] < 0) open = 1;
      t++;
    end
    m_valid = '0;
    s_ready = '1;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int e, e2;
    for (int s = 0; s < NS; s++) last_own[s] = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_busy == '0, "R1 busy after reset", int'(s_busy), 0);
    chk(m_done == '0, "R1 done after reset", int'(m_done), 0);

    // R2 R3 R4: sweep every master, slave, direction and length alone
    for (int m = 0; m < NM; m++)
      for (int s = 0; s < NS; s++)
        for (int w = 0; w < 2; w++)
          for (int l = 0; l < 4; l++) begin
            clear_plan();
            act[m] = 1; tgt[m] = s; dir[m] = w; ln[m] = l;
            run_plan(100);
            if (allowed(m, s) == 0) begin
              chk(fin[m] == 0 && er[m] == 1, "R4 denied completes at once", fin[m], 0);
              chk(s_busy[s] == 1'b0, "R4 denied slave idle", int'(s_busy[s]), 0);
            end else begin
              e = due(m, s, w) + l + 1;
              chk(fin[m] == e && er[m] == 0, "R2/R3 latency", fin[m], e);
            end
          end

    // R6: equal priority masters 0 and 1 on slave 0
    clear_plan();
    act[0] = 1; tgt[0] = 0; dir[0] = 0; ln[0] = 0;
    act[1] = 1; tgt[1] = 0; dir[1] = 0; ln[1] = 0;
    run_plan(100);
    e = due(0, 0, 0) + 1;
    e2 = e + 1 + due(1, 0, 0) + 1;
    chk(fin[0] == e, "R6 lower index first", fin[0], e);
    chk(fin[1] == e2, "R6 second after idle cycle", fin[1], e2);

    // R5: priority 3 master beats priority 1 master
    clear_plan();
    act[0] = 1; tgt[0] = 0; dir[0] = 0; ln[0] = 0;
    act[2] = 1; tgt[2] = 0; dir[2] = 0; ln[2] = 0;
    run_plan(100);
    e = due(2, 0, 0) + 1;
    e2 = e + 1 + due(0, 0, 0) + 1;
    chk(fin[2] == e, "R5 high priority first", fin[2], e);
    chk(fin[0] == e2, "R5 low priority after", fin[0], e2);

    // R7: burst in flight is not cut by later higher-priority requests
    clear_plan();
    act[0] = 1; tgt[0] = 0; dir[0] = 0; ln[0] = 3;
    act[1] = 1; tgt[1] = 0; dir[1] = 1; ln[1] = 0; st[1] = 2;
    act[2] = 1; tgt[2] = 0; dir[2] = 0; ln[2] = 0; st[2] = 2;
    run_plan(100);
    e = due(0, 0, 0) + 4;
    chk(fin[0] == e, "R7 burst not interrupted", fin[0], e);
    e = e + 1 + due(2, 0, 0) + 1;
    chk(fin[2] == e, "R7 next owner by priority", fin[2], e);
    e = e + 1 + due(1, 0, 1) + 1;
    chk(fin[1] == e, "R7 third owner", fin[1], e);

    // R8: ready low for two data cycles on slave 1
    clear_plan();
    act[1] = 1; tgt[1] = 1; dir[1] = 0; ln[1] = 1;
    e = due(1, 1, 0);
    rdy_on[1] = e + 1 + 2;
    run_plan(100);
    e = e + 2 + 2;
    chk(fin[1] == e, "R8 stall delays completion", fin[1], e);

    // R9: slave 0 locked to master 1, master 2 waits until release
    clear_plan();
    lock_en[0] = 1'b1; lock_id[1:0] = 2'd1; lock_off = 30;
    act[1] = 1; tgt[1] = 0; dir[1] = 0; ln[1] = 0;
    act[2] = 1; tgt[2] = 0; dir[2] = 0; ln[2] = 0;
    run_plan(100);
    e = due(1, 0, 0) + 1;
    chk(fin[1] == e, "R9 lock master granted", fin[1], e);
    e = 30 + due(2, 0, 0) + 1;
    chk(fin[2] == e, "R9 others held until release", fin[2], e);

    // R9: lock on a slave that is not lockable has no effect
    clear_plan();
    lock_en[1] = 1'b1; lock_id[3:2] = 2'd1;
    act[2] = 1; tgt[2] = 1; dir[2] = 0; ln[2] = 0;
    run_plan(100);
    e = due(2, 1, 0) + 1;
    chk(fin[2] == e, "R9 lock ignored on slave 1", fin[2], e);
    lock_en = '0;

    // R10: after all traffic, nothing remains owned or beating
    @(negedge clk);
    chk(s_busy == '0 && s_beat == '0, "R10 idle at end", int'(s_busy), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule